// File: doc/BRIEF.md
# Block Copy and Search Sequencer

This block runs the byte-string copy and byte-string search operations of an 8-bit processor as a standalone engine. After a start strobe it takes a source pointer, a destination pointer, a byte count, the accumulator and the current flag byte. It then steps through memory one byte per iteration, using a byte-wide synchronous memory port. Each iteration either copies the byte at the source to the destination, or compares it against the accumulator. The pointers move up or down by one, the count drops by one, and a new flag byte is produced.

A 3-bit mode selects the operation. Bit 2 set means compare, clear means copy. Bit 1 set means repeat until a stop condition, clear means a single step. Bit 0 set means the pointers decrement, clear means they increment. One clock equals one processor clock state, so the busy window has the exact length of the processor operation. The surrounding core reads the pointers, count and flags back once the done pulse arrives.

Top module: `blkseq_top`

## Requirements
- R1: After reset, busy, done and mem_we are 0, and src_out, dst_out, cnt_out and flags_out are all 0.
- R2: When start is high and busy is low, the block loads mode, acc_in, src_in, dst_in, cnt_in and flags_in, and busy is high from the next cycle. A start while busy is ignored and leaves every result unchanged.
- R3: A copy iteration reads the byte at the source address. In the next cycle it drives the destination address with that byte and raises mem_we for exactly one cycle. Both pointers then move by one, incrementing when mode bit 0 is 0 and decrementing when it is 1, with 16-bit wrap. The count drops by one.
- R4: A compare iteration reads the byte at the source address and never raises mem_we. The source pointer moves by one in the selected direction, the destination pointer is unchanged, and the count drops by one.
- R5: An iteration that is followed by another lasts 21 cycles of busy. The last iteration, and any single-step operation, lasts 16 cycles. done is high for exactly one cycle, in the cycle right after busy falls.
- R6: A count of 0 at start becomes 0xFFFF after the first iteration. A repeating copy stops after the iteration that brings the count to 0.
- R7: A repeating compare stops after the iteration where the count reaches 0, or after the iteration where the byte equals the accumulator, whichever comes first.
- R8: The flag byte is laid out from bit 7 to bit 0 as S, Z, bit5, H, bit3, P/V, N, C. After a copy iteration, S, Z and C keep their previous values, and H = N = 0. P/V is 1 when the new count is nonzero. Bit 5 is bit 1 and bit 3 is bit 3 of (accumulator + copied byte) mod 256.
- R9: After a compare iteration, let d = (accumulator − byte) mod 256. S = d[7], Z = (d == 0), and H = 1 when the low nibble of the accumulator is below that of the byte. N = 1, C is kept, and P/V is 1 when the new count is nonzero. Bit 5 is bit 1 and bit 3 is bit 3 of (d − H) mod 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one processor clock state per cycle |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch strobe, taken only while idle |
| mode | input | 3 | [2] compare, [1] repeat, [0] decrement |
| acc_in | input | 8 | Accumulator value |
| src_in | input | 16 | Initial source pointer |
| dst_in | input | 16 | Initial destination pointer |
| cnt_in | input | 16 | Initial byte count |
| flags_in | input | 8 | Flag byte before the operation |
| mem_rdata | input | 8 | Read data for mem_addr, same cycle |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Write data |
| mem_we | output | 1 | One-cycle write strobe |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| flags_out | output | 8 | Current flag byte |
| src_out | output | 16 | Current source pointer |
| dst_out | output | 16 | Current destination pointer |
| cnt_out | output | 16 | Current byte count |

## Verification
The hardest situations to reach are the ones where two stop rules, or a wrap, meet in the same iteration. One is a repeating search whose count starts at zero: it only ends because the first byte matches, leaving the count at 0xFFFF with P/V set. Another is a pointer that crosses 0x0000 or 0xFFFF partway through an operation. The stimulus sweeps all eight modes over cases that place the source next to both address ends, and sets the accumulator to a chosen byte of a known memory pattern so that a match falls on a chosen iteration. Overlapping source and destination ranges show that every write lands before the next read. A second start raised in the middle of a run shows the live state is not disturbed.

// File: rtl/blkseq_pkg.sv
`timescale 1ns/1ps
package blkseq_pkg;

    typedef struct packed {
        logic cmp;
        logic rpt;
        logic dec;
    } bmode_t;

    localparam int FB_S  = 7;
    localparam int FB_Z  = 6;
    localparam int FB_5  = 5;
    localparam int FB_H  = 4;
    localparam int FB_3  = 3;
    localparam int FB_PV = 2;
    localparam int FB_N  = 1;
    localparam int FB_C  = 0;

    typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} seq_state_t;

    function automatic logic [7:0] copy_flag_byte(
        input logic [7:0] fprev,
        input logic [7:0] accv,
        input logic [7:0] bval,
        input logic       more
    );
        logic [7:0] s;
        logic [7:0] f;
        s        = accv + bval;
        f        = fprev;
        f[FB_H]  = 1'b0;
        f[FB_N]  = 1'b0;
        f[FB_PV] = more;
        f[FB_5]  = s[1];
        f[FB_3]  = s[3];
        return f;
    endfunction

    function automatic logic [7:0] cmp_flag_byte(
        input logic [7:0] fprev,
        input logic [7:0] accv,
        input logic [7:0] bval,
        input logic       more
    );
        logic [7:0] d;
        logic [7:0] adj;
        logic       hb;
        logic [7:0] f;
        d        = accv - bval;
        hb       = (accv[3:0] < bval[3:0]);
        adj      = d - {7'd0, hb};
        f        = fprev;
        f[FB_S]  = d[7];
        f[FB_Z]  = (d == 8'd0);
        f[FB_H]  = hb;
        f[FB_N]  = 1'b1;
        f[FB_PV] = more;
        f[FB_5]  = adj[1];
        f[FB_3]  = adj[3];
        return f;
    endfunction

endpackage

// File: rtl/blkseq_ctrl.sv
`timescale 1ns/1ps
module blkseq_ctrl
    import blkseq_pkg::*;
#(
    parameter int LONG_T  = 21,
    parameter int SHORT_T = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic cont,
    output logic accept,
    output logic busy,
    output logic done,
    output logic ph_rd,
    output logic ph_wr,
    output logic ph_upd
);
    localparam int TW = $clog2(LONG_T + 1);
    localparam logic [TW-1:0] T_LAST_LONG  = TW'(LONG_T - 1);
    localparam logic [TW-1:0] T_LAST_SHORT = TW'(SHORT_T - 1);

    seq_state_t    st_q;
    logic [TW-1:0] tcnt_q;
    logic          done_q;
    logic          last;
    logic          run;

    assign run    = (st_q == ST_RUN);
    assign last   = run && ((tcnt_q == T_LAST_SHORT && !cont) || tcnt_q == T_LAST_LONG);
    assign accept = !run && start;
    assign busy   = run;
    assign done   = done_q;
    assign ph_rd  = run && (tcnt_q == TW'(0));
    assign ph_wr  = run && (tcnt_q == TW'(1));
    assign ph_upd = run && (tcnt_q == TW'(2));

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            tcnt_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!run) begin
                if (start) begin
                    st_q   <= ST_RUN;
                    tcnt_q <= '0;
                end
            end else if (last) begin
                tcnt_q <= '0;
                if (!cont) begin
                    st_q   <= ST_IDLE;
                    done_q <= 1'b1;
                end
            end else begin
                tcnt_q <= tcnt_q + TW'(1);
            end
        end
    end

    // R5: completion strobe is a single cycle and follows a busy cycle
    a_r5_done_single: assert property (@(posedge clk) disable iff (rst) done |=> !done);
    a_r5_done_after_busy: assert property (@(posedge clk) disable iff (rst) done |-> $past(run));
    // R5: an iteration never ends before the short length
    a_r5_min_len: assert property (@(posedge clk) disable iff (rst) last |-> tcnt_q >= T_LAST_SHORT);
    // R2: a start seen while running does not end the run
    a_r2_busy_start: assert property (@(posedge clk) disable iff (rst)
        (run && start && !last) |=> run);

endmodule

// File: rtl/blkseq_flagcalc.sv
`timescale 1ns/1ps
module blkseq_flagcalc
    import blkseq_pkg::*;
(
    input  logic       is_cmp,
    input  logic [7:0] fprev,
    input  logic [7:0] accv,
    input  logic [7:0] bval,
    input  logic       more,
    output logic [7:0] fnext
);
    always_comb begin
        if (is_cmp) fnext = cmp_flag_byte(fprev, accv, bval, more);
        else        fnext = copy_flag_byte(fprev, accv, bval, more);
    end
endmodule

// File: rtl/blkseq_datapath.sv
`timescale 1ns/1ps
module blkseq_datapath
    import blkseq_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          accept,
    input  logic [2:0]    mode_in,
    input  logic [7:0]    acc_in,
    input  logic [AW-1:0] src_in,
    input  logic [AW-1:0] dst_in,
    input  logic [CW-1:0] cnt_in,
    input  logic [7:0]    flags_in,
    input  logic          ph_rd,
    input  logic          ph_wr,
    input  logic          ph_upd,
    input  logic [7:0]    mem_rdata,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    output logic          mem_we,
    output logic [AW-1:0] src_q,
    output logic [AW-1:0] dst_q,
    output logic [CW-1:0] cnt_q,
    output logic [7:0]    flags_q,
    output logic          cont
);
    bmode_t        mode_q;
    logic [7:0]    acc_q;
    logic [7:0]    bval_q;
    logic [CW-1:0] cnt_next;
    logic          more;
    logic [7:0]    flags_next;
    logic [AW-1:0] src_next;
    logic [AW-1:0] dst_next;

    function automatic logic [AW-1:0] step_ptr(input logic [AW-1:0] p, input logic dn);
        return dn ? (p - AW'(1)) : (p + AW'(1));
    endfunction

    assign cnt_next = cnt_q - CW'(1);
    assign more     = (cnt_next != '0);
    assign src_next = step_ptr(src_q, mode_q.dec);
    assign dst_next = mode_q.cmp ? dst_q : step_ptr(dst_q, mode_q.dec);
    assign cont     = mode_q.rpt && flags_q[FB_PV] && !(mode_q.cmp && flags_q[FB_Z]);

    assign mem_addr  = ph_wr ? dst_q : src_q;
    assign mem_wdata = bval_q;
    assign mem_we    = ph_wr && !mode_q.cmp;

    blkseq_flagcalc u_flag (
        .is_cmp (mode_q.cmp),
        .fprev  (flags_q),
        .accv   (acc_q),
        .bval   (bval_q),
        .more   (more),
        .fnext  (flags_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= '0;
            acc_q   <= '0;
            bval_q  <= '0;
            src_q   <= '0;
            dst_q   <= '0;
            cnt_q   <= '0;
            flags_q <= '0;
        end else if (accept) begin
            mode_q  <= bmode_t'(mode_in);
            acc_q   <= acc_in;
            src_q   <= src_in;
            dst_q   <= dst_in;
            cnt_q   <= cnt_in;
            flags_q <= flags_in;
        end else begin
            if (ph_rd) bval_q <= mem_rdata;
            if (ph_upd) begin
                src_q   <= src_next;
                dst_q   <= dst_next;
                cnt_q   <= cnt_next;
                flags_q <= flags_next;
            end
        end
    end

    // R3: write strobe lasts one cycle
    a_r3_we_pulse: assert property (@(posedge clk) disable iff (rst) mem_we |=> !mem_we);
    // R3: each update lowers the count by one
    a_r3_cnt_step: assert property (@(posedge clk) disable iff (rst)
        ph_upd |=> cnt_q == $past(cnt_q) - CW'(1));
    // R4: compare never writes and leaves the destination alone
    a_r4_no_write: assert property (@(posedge clk) disable iff (rst) mode_q.cmp |-> !mem_we);
    a_r4_dst_hold: assert property (@(posedge clk) disable iff (rst)
        (ph_upd && mode_q.cmp) |=> $stable(dst_q));
    // R8 / R9: P/V tracks a nonzero count after every update
    a_r8_pv_count: assert property (@(posedge clk) disable iff (rst)
        ph_upd |=> flags_q[FB_PV] == (cnt_q != '0));
    // R8: copy clears H and N
    a_r8_copy_hn: assert property (@(posedge clk) disable iff (rst)
        (ph_upd && !mode_q.cmp) |=> (!flags_q[FB_H] && !flags_q[FB_N]));
    // R9: compare sets N and keeps C
    a_r9_cmp_nc: assert property (@(posedge clk) disable iff (rst)
        (ph_upd && mode_q.cmp) |=> (flags_q[FB_N] && flags_q[FB_C] == $past(flags_q[FB_C])));

endmodule

// File: rtl/blkseq_top.sv
`timescale 1ns/1ps
module blkseq_top
    import blkseq_pkg::*;
#(
    parameter int AW      = 16,
    parameter int CW      = 16,
    parameter int LONG_T  = 21,
    parameter int SHORT_T = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [2:0]    mode,
    input  logic [7:0]    acc_in,
    input  logic [AW-1:0] src_in,
    input  logic [AW-1:0] dst_in,
    input  logic [CW-1:0] cnt_in,
    input  logic [7:0]    flags_in,
    input  logic [7:0]    mem_rdata,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    output logic          mem_we,
    output logic          busy,
    output logic          done,
    output logic [7:0]    flags_out,
    output logic [AW-1:0] src_out,
    output logic [AW-1:0] dst_out,
    output logic [CW-1:0] cnt_out
);
    logic accept;
    logic cont;
    logic ph_rd;
    logic ph_wr;
    logic ph_upd;

    blkseq_ctrl #(.LONG_T(LONG_T), .SHORT_T(SHORT_T)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .cont   (cont),
        .accept (accept),
        .busy   (busy),
        .done   (done),
        .ph_rd  (ph_rd),
        .ph_wr  (ph_wr),
        .ph_upd (ph_upd)
    );

    blkseq_datapath #(.AW(AW), .CW(CW)) u_dp (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .mode_in   (mode),
        .acc_in    (acc_in),
        .src_in    (src_in),
        .dst_in    (dst_in),
        .cnt_in    (cnt_in),
        .flags_in  (flags_in),
        .ph_rd     (ph_rd),
        .ph_wr     (ph_wr),
        .ph_upd    (ph_upd),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .src_q     (src_out),
        .dst_q     (dst_out),
        .cnt_q     (cnt_out),
        .flags_q   (flags_out),
        .cont      (cont)
    );

    // R1: idle block never writes
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst) !busy |-> !mem_we);

endmodule

// File: tb/sim_blkseq_top.sv
`timescale 1ns/1ps
module sim_blkseq_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [2:0]  mode;
    logic [7:0]  acc_in;
    logic [15:0] src_in, dst_in, cnt_in;
    logic [7:0]  flags_in;
    logic [7:0]  mem_rdata;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_we, busy, done;
    logic [7:0]  flags_out;
    logic [15:0] src_out, dst_out, cnt_out;

    logic [7:0] mem [0:255];
    logic [7:0] emem [0:255];
    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    blkseq_top u0 (
        .clk(clk), .rst(rst), .start(start), .mode(mode), .acc_in(acc_in),
        .src_in(src_in), .dst_in(dst_in), .cnt_in(cnt_in), .flags_in(flags_in),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .busy(busy), .done(done), .flags_out(flags_out),
        .src_out(src_out), .dst_out(dst_out), .cnt_out(cnt_out)
    );

    assign mem_rdata = mem[mem_addr[7:0]];
    always @(posedge clk) if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic fill_mem();
        for (int i = 0; i < 256; i++) mem[i] = 8'((i * 37 + 11) & 255);
    endtask

    task automatic run_op(input logic [2:0] md, input logic [7:0] a, input logic [15:0] s,
                          input logic [15:0] d, input logic [15:0] c, input logic [7:0] f,
                          input bit poke);
        logic [15:0] es, ed, ec;
        logic [7:0]  ef, b, t, dif, adj;
        logic        h;
        int ecyc, ewr, cyc, wr, guard, diffs;
        bit go, pk;
        es = s; ed = d; ec = c; ef = f; ecyc = 0; ewr = 0;
        for (int i = 0; i < 256; i++) emem[i] = mem[i];
        go = 1'b1;
        while (go) begin
            b = emem[es[7:0]];
            ec = ec - 16'd1;
            if (!md[2]) begin
                // R3 / R8: copy iteration model
                emem[ed[7:0]] = b; ewr++;
                t = a + b;
                ef[4] = 1'b0; ef[1] = 1'b0; ef[2] = (ec != 0); ef[5] = t[1]; ef[3] = t[3];
                ed = md[0] ? ed - 16'd1 : ed + 16'd1;
            end else begin
                // R4 / R9: compare iteration model
                dif = a - b;
                h = (a[3:0] < b[3:0]);
                adj = dif - {7'd0, h};
                ef[7] = dif[7]; ef[6] = (dif == 0); ef[4] = h; ef[1] = 1'b1;
                ef[2] = (ec != 0); ef[5] = adj[1]; ef[3] = adj[3];
            end
            es = md[0] ? es - 16'd1 : es + 16'd1;
            // R6 / R7: stop rules
            go = md[1] && (ec != 0) && !(md[2] && ef[6]);
            ecyc += go ? 21 : 16;
        end
        @(negedge clk);
        mode = md; acc_in = a; src_in = s; dst_in = d; cnt_in = c; flags_in = f; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0; wr = 0; guard = 0; pk = 1'b0;
        while (!done && guard < 100000) begin
            if (busy) cyc++;
            if (mem_we) wr++;
            if (poke && cyc == 5 && !pk) begin
                // R2: second start while busy with different operands
                mode = ~md; acc_in = ~a; src_in = 16'h1234; dst_in = 16'h4321;
                cnt_in = 16'd7; flags_in = ~f; start = 1'b1; pk = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            guard++;
        end
        start = 1'b0;
        chk("R5 done seen", {31'd0, done}, 32'd1);
        chk("R5 busy length", cyc, ecyc);
        chk("R3 write strobes", wr, ewr);
        chk("R3 R4 source pointer", {16'd0, src_out}, {16'd0, es});
        chk("R3 R4 destination pointer", {16'd0, dst_out}, {16'd0, ed});
        chk("R6 R7 count", {16'd0, cnt_out}, {16'd0, ec});
        chk(md[2] ? "R9 flags" : "R8 flags", {24'd0, flags_out}, {24'd0, ef});
        diffs = 0;
        for (int i = 0; i < 256; i++) if (mem[i] !== emem[i]) diffs++;
        chk("R3 R4 memory image", diffs, 0);
        @(negedge clk);
        chk("R5 done one cycle", {31'd0, done}, 32'd0);
        if (poke) chk("R2 busy start ignored", {31'd0, busy}, 32'd0);
    endtask

    initial begin
        #(20 * 190000);
        n_fail++;
        $display("FAIL R5 watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0; mode = '0; acc_in = '0; src_in = '0; dst_in = '0;
        cnt_in = '0; flags_in = '0;
        fill_mem();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk("R1 busy", {31'd0, busy}, 32'd0);
        chk("R1 done", {31'd0, done}, 32'd0);
        chk("R1 mem_we", {31'd0, mem_we}, 32'd0);
        chk("R1 pointers", {src_out, dst_out}, 32'd0);
        chk("R1 count and flags", {8'd0, cnt_out, flags_out}, 32'd0);

        for (int m = 0; m < 8; m++) begin
            logic [2:0] md;
            md = 3'(m);
            fill_mem();
            // match on the third byte when searching upward
            run_op(md, mem[8'h12], 16'h0010, 16'h0080, 16'd5, 8'h00, 1'b0);
            fill_mem();
            // pointers cross the ends of the address space
            run_op(md, 8'h5A, 16'hFFFE, 16'h0001, 16'd3, 8'hFF, 1'b0);
            fill_mem();
            run_op(md, 8'h00, 16'h0001, 16'hFFFF, 16'd1, 8'hA5, 1'b0);
            fill_mem();
            // overlapping ranges
            run_op(md, 8'h3C, 16'h0040, 16'h0041, 16'd4, 8'h81, 1'b0);
            fill_mem();
            // R6: zero count wraps; repeating search must match at once
            if (!(md[1] && !md[2]))
                run_op(md, mem[8'h20], 16'h0020, 16'h0090, 16'd0, 8'h41, 1'b0);
        end
        fill_mem();
        // R2: start while running is ignored (repeating copy and repeating search)
        run_op(3'b010, 8'h11, 16'h0030, 16'h00A0, 16'd4, 8'h00, 1'b1);
        fill_mem();
        run_op(3'b111, 8'h00, 16'h00C0, 16'h0000, 16'd3, 8'h01, 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule